// File: doc/BRIEF.md
# Flash Erase Block Select Unit

This unit holds the erase selection for a 128-kbyte flash array that is split into ten blocks of unequal size. Software writes two byte-wide select registers over a simple register bus. The unit accepts a write only if it leaves no more than one select bit set across both registers. The registers are forced to zero while the flash write-enable pin is low, while the software write-enable bit is clear, or while the chip is in a power-down mode. Another part of the chip can then present an erase address and receive a single permit bit. That bit is high only when the address falls inside the one block that is selected.

The unit does not model the flash array, erase pulses or any erase timing. It only selects, protects and decodes.

Top module: `flash_erase_sel`

## Requirements
- R1: After the active-low asynchronous reset, both select registers read 0x00 and the permit output is low.
- R2: The low register (bus_sel_i=0) holds the selects for blocks 0 to 7 in bits 0 to 7. The high register (bus_sel_i=1) holds block 8 in bit 0 and block 9 in bit 1. An accepted write can be read back in the cycle after the write edge. Reads are combinational on bus_sel_i.
- R3: Bits 7 to 2 of the high register always read 0, and writes to them are ignored.
- R4: While wen_pin_i is low, both registers are cleared at every clock edge and bus writes are ignored.
- R5: While wen_pin_i is high and sw_wen_i is low, both registers are cleared at every clock edge and bus writes are ignored.
- R6: pwr_mode_i codes 4 to 7 (software standby, hardware standby, watch, subsleep) are power-down modes: they clear both registers and block writes. Codes 0 to 3 (active, medium-speed, sleep, module stop) have no effect on the registers.
- R7: A write that would leave more than one select bit set across the two registers is rejected, and both registers keep their previous values.
- R8: When a clear condition and a bus write occur in the same cycle, the clear wins and the registers become 0x00.
- R9: erase_ok_o is high only when exactly one block is selected and erase_addr_i lies in that block. The block map is: blocks 0 to 3 are 1 KB each, starting at 0x000000, 0x000400, 0x000800 and 0x000C00. Block 4 is 0x001000 to 0x007FFF. Block 5 is 0x008000 to 0x00BFFF. Block 6 is 0x00C000 to 0x00DFFF. Block 7 is 0x00E000 to 0x00FFFF. Block 8 is 0x010000 to 0x017FFF. Block 9 is 0x018000 to 0x01FFFF.
- R10: An erase address at or above 0x020000 never gives a permit, whatever is selected.
- R11: At no time is more than one select bit set across both registers. This includes a write to one register while the other register already holds a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_sel_i | input | 1 | Register select: 0 low, 1 high |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the selected register |
| wen_pin_i | input | 1 | Flash write-enable pin level |
| sw_wen_i | input | 1 | Software write-enable bit |
| pwr_mode_i | input | 3 | Current power mode code |
| erase_addr_i | input | 24 | Byte address of the intended erase |
| erase_ok_o | output | 1 | Erase permitted at erase_addr_i |

## Verification
The bench walks a single selection through all ten blocks. For each block it probes the first and last byte of the block and the bytes just outside it. A decoder with an off-by-one boundary, or with the 28 KB block 4 placed wrongly, would grant or refuse a permit on those bytes. The bench also tries double selections within one register and across the two registers. A missing cross-register check would leave two bits set. It writes while each clear condition holds, and in the very cycle a clear begins. A write-before-clear priority would leave a stale select. It steps through all eight power mode codes: treating sleep or medium-speed as power-down would wrongly wipe the selection. Finally it probes addresses above the array, where an unmasked high address could still grant a permit.

// File: rtl/flash_sel_pkg.sv
package flash_sel_pkg;
  parameter int NUM_BLK = 10;
  parameter int ADDR_W  = 24;
  parameter int REG_W   = 8;
  localparam int HI_W   = NUM_BLK - REG_W;

  typedef enum logic [2:0] {
    PM_ACTIVE = 3'd0,
    PM_MEDIUM = 3'd1,
    PM_SLEEP  = 3'd2,
    PM_MSTOP  = 3'd3,
    PM_SWSTBY = 3'd4,
    PM_HWSTBY = 3'd5,
    PM_WATCH  = 3'd6,
    PM_SUBSLP = 3'd7
  } pwr_mode_e;

  // block i spans [blk_base(i), blk_base(i+1))
  function automatic logic [ADDR_W-1:0] blk_base(input int idx);
    case (idx)
      0:       return ADDR_W'('h000000);
      1:       return ADDR_W'('h000400);
      2:       return ADDR_W'('h000800);
      3:       return ADDR_W'('h000C00);
      4:       return ADDR_W'('h001000);
      5:       return ADDR_W'('h008000);
      6:       return ADDR_W'('h00C000);
      7:       return ADDR_W'('h00E000);
      8:       return ADDR_W'('h010000);
      9:       return ADDR_W'('h018000);
      default: return ADDR_W'('h020000);
    endcase
  endfunction

  function automatic logic is_pwr_down(input pwr_mode_e m);
    case (m)
      PM_SWSTBY, PM_HWSTBY, PM_WATCH, PM_SUBSLP: return 1'b1;
      default:                                   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fbsel_guard.sv
module fbsel_guard
  import flash_sel_pkg::*;
(
  input  logic       wen_pin_i,
  input  logic       sw_wen_i,
  input  logic [2:0] pwr_mode_i,
  output logic       clr_o
);
  pwr_mode_e mode;
  logic      pdown;

  always_comb begin
    mode  = pwr_mode_e'(pwr_mode_i);
    pdown = is_pwr_down(mode);
    clr_o = !wen_pin_i || !sw_wen_i || pdown;
  end
endmodule

// File: rtl/fbsel_regs.sv
module fbsel_regs
  import flash_sel_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               we_i,
  input  logic               hi_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic [NUM_BLK-1:0] sel_o
);
  logic [NUM_BLK-1:0] sel_q, cand;
  logic               cand_ok;

  always_comb begin
    cand = sel_q;
    if (hi_i) cand[NUM_BLK-1:REG_W] = wdata_i[HI_W-1:0];
    else      cand[REG_W-1:0]       = wdata_i;
    cand_ok = ($countones(cand) <= 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sel_q <= '0;
    else if (clr_i)             sel_q <= '0;
    else if (we_i && cand_ok)   sel_q <= cand;
  end

  always_comb begin
    rdata_o = '0;
    if (hi_i) rdata_o[HI_W-1:0] = sel_q[NUM_BLK-1:REG_W];
    else      rdata_o           = sel_q[REG_W-1:0];
  end

  assign sel_o = sel_q;

  assert_single_sel_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_q));
  assert_clear_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sel_q == '0));
  assert_reject_multi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clr_i && ($countones(cand) > 1)) |=> $stable(sel_q));
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !clr_i) |=> $stable(sel_q));
endmodule

// File: rtl/fbsel_addr_dec.sv
module fbsel_addr_dec
  import flash_sel_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_BLK-1:0] hit_o
);
  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    localparam logic [ADDR_W-1:0] LO = blk_base(g);
    localparam logic [ADDR_W-1:0] HI = blk_base(g + 1);
    assign hit_o[g] = (addr_i >= LO) && (addr_i < HI);
  end

  always_comb begin
    assert_hit_onehot_R9: assert ($onehot0(hit_o));
    if (addr_i >= blk_base(NUM_BLK))
      assert_above_array_R10: assert (hit_o == '0);
  end
endmodule

// File: rtl/flash_erase_sel.sv
module flash_erase_sel
  import flash_sel_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic        bus_sel_i,
  input  logic [7:0]  bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  input  logic        wen_pin_i,
  input  logic        sw_wen_i,
  input  logic [2:0]  pwr_mode_i,
  input  logic [23:0] erase_addr_i,
  output logic        erase_ok_o
);
  logic               clr;
  logic [NUM_BLK-1:0] sel, hit;

  fbsel_guard u_guard (
    .wen_pin_i (wen_pin_i),
    .sw_wen_i  (sw_wen_i),
    .pwr_mode_i(pwr_mode_i),
    .clr_o     (clr)
  );

  fbsel_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .we_i   (bus_we_i),
    .hi_i   (bus_sel_i),
    .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o),
    .sel_o  (sel)
  );

  fbsel_addr_dec u_dec (
    .addr_i(erase_addr_i),
    .hit_o (hit)
  );

  assign erase_ok_o = |(sel & hit);

  assert_permit_sel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_ok_o |-> ($countones(sel) == 1));
  assert_pin_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_pin_i |=> (sel == '0));
  assert_sw_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_pin_i && !sw_wen_i) |=> (sel == '0));
  assert_pdown_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_mode_i[2] |=> (sel == '0));
  assert_hi_pad_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_sel_i |-> (bus_rdata_o[7:2] == 6'd0));
endmodule

// File: tb/flash_erase_sel_tb_top.sv
`timescale 1ns/1ps
module flash_erase_sel_tb_top;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic        we = 0, hsel = 0, pin = 1, swe = 1;
  logic [7:0]  wd = 0;
  logic [2:0]  pm = 0;
  logic [23:0] ea = 0;
  logic [7:0]  rdata;
  logic        ok;

  int n_cmp = 0, n_bad = 0;
  int ref_lo = 0, ref_hi = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_erase_sel dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(we), .bus_sel_i(hsel),
    .bus_wdata_i(wd), .bus_rdata_o(rdata), .wen_pin_i(pin), .sw_wen_i(swe),
    .pwr_mode_i(pm), .erase_addr_i(ea), .erase_ok_o(ok)
  );

  function automatic int blk_of(int a);
    if (a < 'h1000)  return a / 1024;
    if (a < 'h8000)  return 4;
    if (a < 'hC000)  return 5;
    if (a < 'hE000)  return 6;
    if (a < 'h10000) return 7;
    if (a < 'h18000) return 8;
    if (a < 'h20000) return 9;
    return -1;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(string tag, bit w, bit h, int d, bit p, bit s, int m, int a);
    int sel, b, e_ok, cand;
    @(negedge clk);
    we = w; hsel = h; wd = 8'(d); pin = p; swe = s; pm = 3'(m); ea = 24'(a);
    #2;
    sel = (ref_hi << 8) | ref_lo;
    b = blk_of(a);
    e_ok = (b >= 0) ? ((sel >> b) & 1) : 0;
    check(tag, rdata, h ? ref_hi : ref_lo);
    check(tag, ok, e_ok);
    @(posedge clk);
    if (!p || !s || m >= 4) begin
      ref_lo = 0; ref_hi = 0;
    end else if (w) begin
      cand = h ? (((d & 3) << 8) | ref_lo) : ((ref_hi << 8) | (d & 'hFF));
      if ($countones(cand) <= 1) begin
        ref_lo = cand & 'hFF; ref_hi = cand >> 8;
      end
    end
  endtask

  task automatic wr(string tag, bit h, int d);
    cyc(tag, 1, h, d, 1, 1, 0, 0);
  endtask
  task automatic rd(string tag, bit h, int a);
    cyc(tag, 0, h, 0, 1, 1, 0, a);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int bases[11] = '{'h0, 'h400, 'h800, 'hC00, 'h1000, 'h8000, 'hC000, 'hE000,
                      'h10000, 'h18000, 'h20000};
    #5;
    check("R1", rdata, 0);
    check("R1", ok, 0);
    repeat (2) @(posedge clk);
    rst_ni = 1;
    rd("R1", 0, 0);
    rd("R1", 1, 'h18000);

    // walk every block, probe its edges
    for (int i = 0; i < 10; i++) begin
      wr("R2", 0, 0);
      wr("R2", 1, 0);
      wr("R2", i >= 8, 1 << (i % 8));
      rd("R2", i >= 8, bases[i]);
      rd("R9", 0, bases[i + 1] - 1);
      rd("R9", 0, bases[i + 1]);
      if (i > 0) rd("R9", 1, bases[i] - 1);
      rd("R9", 0, (bases[i] + bases[i + 1]) / 2);
    end
    // block 9 still set
    rd("R10", 1, 'h20000);
    rd("R10", 1, 'hFFFFFF);
    rd("R10", 0, 'h1FFFF);

    // high register padding
    wr("R3", 1, 'hFC);
    rd("R3", 1, 'h18000);
    wr("R3", 1, 'hFE);
    rd("R3", 1, 'h10000);

    // double selections
    wr("R7", 1, 0);
    wr("R7", 0, 'h10);
    wr("R7", 0, 'h11);
    rd("R7", 0, 'h8000);
    wr("R7", 1, 'h03);
    rd("R7", 1, 0);
    wr("R11", 1, 'h01);
    rd("R11", 1, 'h10000);
    rd("R11", 0, 'h8000);
    wr("R11", 0, 'h00);
    wr("R11", 1, 'h01);
    rd("R11", 1, 'h10000);

    // pin low clears, writes ignored
    wr("R4", 1, 0);
    wr("R4", 0, 'h04);
    cyc("R4", 0, 0, 0, 0, 1, 0, 'h800);
    cyc("R4", 1, 0, 'h08, 0, 1, 0, 'hC00);
    rd("R4", 0, 'hC00);

    // software enable off
    wr("R5", 0, 'h02);
    cyc("R5", 0, 0, 0, 1, 0, 0, 'h400);
    cyc("R5", 1, 0, 'h02, 1, 0, 0, 'h400);
    rd("R5", 0, 'h400);

    // power modes
    for (int m = 0; m < 8; m++) begin
      wr("R6", 0, 'h80);
      cyc("R6", 0, 0, 0, 1, 1, m, 'hE000);
      cyc("R6", 1, 0, 'h40, 1, 1, m, 'hE000);
      rd("R6", 0, 'hC000);
    end

    // clear and write in the same cycle
    wr("R8", 0, 0);
    cyc("R8", 1, 1, 'h02, 0, 1, 0, 'h18000);
    rd("R8", 1, 'h18000);
    cyc("R8", 1, 0, 'h01, 1, 1, 5, 0);
    rd("R8", 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule